// File: doc/BRIEF.md
# NRZI Bit-Stuffing Serial Line Encoder

This block turns a stream of payload bits into the line signals of a full-speed serial peripheral link. An upstream source presents one bit at a time with a valid/ready handshake and flags the final bit of a packet. The encoder opens every packet with an 8-bit synchronisation pattern and then sends the payload. After six consecutive ones it inserts an extra zero so that the line keeps changing level. The combined stream is NRZI coded and driven onto a complementary pair of data lines. The line drivers are enabled only while a packet is in flight.

A packet ends with two bit times in which both lines are held low. One bit time of the idle level follows, and then the output enable is released. Each clock cycle is one bit time. CRC is appended upstream, and the analog driver and clock recovery sit outside the block. If the source drops valid while a payload bit is due, the packet is cut short and closed in the normal way.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: Out of reset, and between packets, `linePos`=1, `lineNeg`=0, `lineOe`=0 and `inReady`=0.
- R2: A packet starts when `inValid` is high in the idle state. The first output bit appears after the next rising edge. The first 8 encoded bits are the sync value 0x80 sent least significant bit first: seven 0s, then one 1.
- R3: NRZI coding. Starting from the idle level (`linePos`=1), an encoded 0 inverts the line level and an encoded 1 keeps it.
- R4: After six consecutive encoded 1s, a 0 is inserted. The run count includes the final 1 of the sync pattern and is cleared by any 0, whether it is a payload bit or an inserted bit.
- R5: `inReady` is high only in bit slots that take a payload bit. It is low during sync and during inserted-bit slots, so the payload stalls for one bit time at each inserted bit.
- R6: If the final payload bit completes a run of six 1s, one inserted 0 is still sent before the end of the packet.
- R7: End of packet: both lines are low for exactly two bit times. Then one bit time of `linePos`=1, `lineNeg`=0 follows with `lineOe` still high. Then `lineOe` drops.
- R8: `linePos` and `lineNeg` are never both high. Outside the end-of-packet low period, they are always complementary.
- R9: `lineOe` is high from the first sync bit through the closing idle-level bit, and low at all other times.
- R10: If `inValid` is low in a slot that would take a payload bit, the packet ends there with the end-of-packet sequence.
- R11: One encoded bit is produced per clock cycle, with no gaps between the sync, payload, inserted and end-of-packet bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Upstream bit available |
| inBit | input | 1 | Payload bit value |
| inLast | input | 1 | Marks the final payload bit of a packet |
| inReady | output | 1 | Encoder takes `inBit` at this edge |
| linePos | output | 1 | Positive data line |
| lineNeg | output | 1 | Negative data line |
| lineOe | output | 1 | Line driver enable |

## Verification
The assertions watch the following on every cycle:
- the pair is never high together;
- `inReady` never appears while the driver is off;
- the line never holds its level for more than six bit times while enabled;
- a packet always opens with a level change;
- the low period always lasts two bits and is followed by the enabled idle level.

The exact bit stream can only be shown by the bench scenarios, which compare every enabled bit against an independently built expectation. This covers the sync value and its order, the payload order, where inserted bits fall (including after the final bit) and the aborted packet.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_TAIL,
    ST_EOP
  } txState_e;

  // Strobes from control to datapath, one set per bit time
  typedef struct packed {
    logic load;    // send bitVal as the next encoded bit
    logic bitVal;  // encoded bit value when load is set
    logic se0;     // drive both lines low
    logic idleJ;   // restore the idle level
    logic oe;      // enable for the coming bit time
  } txStrobe_t;

endpackage

// File: rtl/nrzi_tx_datapath.sv
module nrzi_tx_datapath
  import nrzi_tx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t strb,
  output logic      stuffDue,
  output logic      linePos,
  output logic      lineNeg,
  output logic      lineOe
);

  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(STUFF_RUN);

  logic             lineLvl;
  logic             se0Reg;
  logic             oeReg;
  logic [RUN_W-1:0] onesCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineLvl <= 1'b1;
      se0Reg  <= 1'b0;
      oeReg   <= 1'b0;
      onesCnt <= '0;
    end else begin
      oeReg <= strb.oe;
      if (strb.load) begin
        lineLvl <= strb.bitVal ? lineLvl : ~lineLvl;
        se0Reg  <= 1'b0;
        onesCnt <= strb.bitVal ? onesCnt + 1'b1 : '0;
      end else if (strb.se0) begin
        se0Reg <= 1'b1;
      end else if (strb.idleJ) begin
        lineLvl <= 1'b1;
        se0Reg  <= 1'b0;
        onesCnt <= '0;
      end
    end
  end

  assign stuffDue = (onesCnt == RUN_LIMIT);
  assign linePos  = se0Reg ? 1'b0 : lineLvl;
  assign lineNeg  = se0Reg ? 1'b0 : ~lineLvl;
  assign lineOe   = oeReg;

endmodule

// File: rtl/nrzi_tx_ctrl.sv
module nrzi_tx_ctrl
  import nrzi_tx_pkg::*;
#(
  parameter int          SYNC_BITS    = 8,
  parameter logic [7:0]  SYNC_PATTERN = 8'h80,
  parameter int          EOP_SE0      = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inBit,
  input  logic      inLast,
  input  logic      stuffDue,
  output logic      inReady,
  output txStrobe_t strb
);

  localparam int CNT_W = $clog2(SYNC_BITS + EOP_SE0 + 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_BITS - 1);
  localparam logic [CNT_W-1:0] SE0_LAST  = CNT_W'(EOP_SE0);

  txState_e         state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [7:0]       syncShifted;

  assign syncShifted = SYNC_PATTERN >> cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    cntNxt   = cnt;
    inReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (inValid) begin
          strb.load   = 1'b1;
          strb.bitVal = SYNC_PATTERN[0];
          strb.oe     = 1'b1;
          stateNxt    = ST_SYNC;
          cntNxt      = CNT_W'(1);
        end
      end
      ST_SYNC: begin
        strb.load   = 1'b1;
        strb.bitVal = syncShifted[0];
        strb.oe     = 1'b1;
        if (cnt == SYNC_LAST) begin
          stateNxt = ST_DATA;
          cntNxt   = '0;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_DATA: begin
        strb.oe = 1'b1;
        if (stuffDue) begin
          strb.load   = 1'b1;
          strb.bitVal = 1'b0;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            strb.load   = 1'b1;
            strb.bitVal = inBit;
            if (inLast) stateNxt = ST_TAIL;
          end else begin
            strb.se0 = 1'b1;
            stateNxt = ST_EOP;
            cntNxt   = CNT_W'(1);
          end
        end
      end
      ST_TAIL: begin
        strb.oe  = 1'b1;
        stateNxt = ST_EOP;
        if (stuffDue) begin
          strb.load   = 1'b1;
          strb.bitVal = 1'b0;
          cntNxt      = '0;
        end else begin
          strb.se0 = 1'b1;
          cntNxt   = CNT_W'(1);
        end
      end
      ST_EOP: begin
        strb.oe = 1'b1;
        if (cnt < SE0_LAST) begin
          strb.se0 = 1'b1;
          cntNxt   = cnt + 1'b1;
        end else begin
          strb.idleJ = 1'b1;
          stateNxt   = ST_IDLE;
          cntNxt     = '0;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx
  import nrzi_tx_pkg::*;
#(
  parameter int         SYNC_BITS    = 8,
  parameter logic [7:0] SYNC_PATTERN = 8'h80,
  parameter int         STUFF_RUN    = 6,
  parameter int         EOP_SE0      = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inBit,
  input  logic inLast,
  output logic inReady,
  output logic linePos,
  output logic lineNeg,
  output logic lineOe
);

  txStrobe_t strb;
  logic      stuffDue;

  nrzi_tx_ctrl #(
    .SYNC_BITS   (SYNC_BITS),
    .SYNC_PATTERN(SYNC_PATTERN),
    .EOP_SE0     (EOP_SE0)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inBit   (inBit),
    .inLast  (inLast),
    .stuffDue(stuffDue),
    .inReady (inReady),
    .strb    (strb)
  );

  nrzi_tx_datapath #(
    .STUFF_RUN(STUFF_RUN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .stuffDue(stuffDue),
    .linePos (linePos),
    .lineNeg (lineNeg),
    .lineOe  (lineOe)
  );

endmodule

// File: rtl/nrzi_stuff_tx_checker.sv
module nrzi_stuff_tx_checker #(
  parameter int STUFF_RUN = 6
) (
  input logic clk,
  input logic rstN,
  input logic inReady,
  input logic linePos,
  input logic lineNeg,
  input logic lineOe
);

  logic       se0;
  logic       prevSe0, prevPos, prevOe;
  logic [4:0] holdCnt;

  assign se0 = !linePos && !lineNeg;

  // Counts bit times in which the enabled line keeps its level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSe0 <= 1'b0;
      prevPos <= 1'b1;
      prevOe  <= 1'b0;
      holdCnt <= '0;
    end else begin
      prevSe0 <= se0;
      prevPos <= linePos;
      prevOe  <= lineOe;
      if (lineOe && prevOe && !se0 && !prevSe0 && linePos == prevPos)
        holdCnt <= holdCnt + 1'b1;
      else
        holdCnt <= '0;
    end
  end

  p_pair_never_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(linePos && lineNeg));

  p_ready_only_enabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> lineOe);

  p_run_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= 5'(STUFF_RUN));

  p_start_toggles_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineOe) |-> (!linePos && lineNeg));

  p_se0_two_bits_r7: assert property (@(posedge clk) disable iff (!rstN)
    (se0 && !prevSe0) |=> se0);

  p_idle_after_se0_r7: assert property (@(posedge clk) disable iff (!rstN)
    (se0 && prevSe0) |=> (lineOe && linePos && !lineNeg));

  p_se0_enabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    se0 |-> lineOe);

endmodule

bind nrzi_stuff_tx nrzi_stuff_tx_checker #(.STUFF_RUN(STUFF_RUN)) u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .inReady(inReady),
  .linePos(linePos),
  .lineNeg(lineNeg),
  .lineOe (lineOe)
);

// File: tb/tb_nrzi_stuff_tx.sv
module tb_nrzi_stuff_tx;

  logic clk = 1'b0;
  logic rstN;
  logic inValid, inBit, inLast;
  logic inReady, linePos, lineNeg, lineOe;

  int checks = 0;
  int fails  = 0;

  logic [2:0] expSeq [0:255];
  int         expKind[0:255];
  int         expLen;
  logic       pay[0:63];

  always #10 clk = ~clk;

  nrzi_stuff_tx dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBit(inBit), .inLast(inLast),
    .inReady(inReady), .linePos(linePos), .lineNeg(lineNeg), .lineOe(lineOe)
  );

  function automatic string reqName(int kind);
    case (kind)
      2: return "R2 R11";
      3: return "R3 R8 R9";
      4: return "R4 R5";
      6: return "R6";
      7: return "R7";
      default: return "R1 R9";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Builds the expected {oe,pos,neg} stream for n payload bits
  task automatic buildExpected(int n);
    logic lvl = 1'b1;
    int   ones = 0;
    int   k = 0;
    for (int i = 0; i < 8 + n; i++) begin
      logic b = (i < 8) ? ((8'h80 >> i) & 1) != 0 : pay[i-8];
      if (!b) lvl = ~lvl;
      ones = b ? ones + 1 : 0;
      expSeq[k] = {1'b1, lvl, ~lvl}; expKind[k] = (i < 8) ? 2 : 3; k++;
      if (ones == 6) begin // inserted zero; R5 stall
        lvl = ~lvl; ones = 0;
        expSeq[k] = {1'b1, lvl, ~lvl}; expKind[k] = (i == 8 + n - 1) ? 6 : 4; k++;
      end
    end
    for (int j = 0; j < 2; j++) begin
      expSeq[k] = 3'b100; expKind[k] = 7; k++;
    end
    expSeq[k] = 3'b110; expKind[k] = 7; k++;
    expSeq[k] = 3'b010; expKind[k] = 1; k++;
    expLen = k;
  endtask

  task automatic runPacket(int n, bit withLast);
    int idx = 0;
    int obs = 0;
    bit started = 0;
    buildExpected(n);
    while (obs < expLen) begin
      @(negedge clk);
      if (started) begin
        check({lineOe, linePos, lineNeg} == expSeq[obs], reqName(expKind[obs]),
              $sformatf("bit %0d of %0d-bit packet", obs, n),
              {lineOe, linePos, lineNeg}, expSeq[obs]);
        obs++;
      end
      inValid = !started || idx < n;
      inBit   = (idx < n) ? pay[idx] : 1'b0;
      inLast  = withLast && idx == n - 1;
      #1;
      if (started && obs < 7) // R5: no payload taken during sync
        check(inReady == 1'b0, "R5", "ready during sync", inReady, 0);
      if (started && inReady && inValid) idx++;
      started = 1;
    end
    inValid = 1'b0;
    check(idx == n, withLast ? "R6" : "R10", "payload bits taken", idx, n);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; inValid = 1'b0; inBit = 1'b0; inLast = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({lineOe, linePos, lineNeg, inReady} == 4'b0100, "R1", "reset outputs",
          {lineOe, linePos, lineNeg, inReady}, 4'b0100);
    rstN = 1'b1;
    @(negedge clk);
    check({lineOe, linePos, lineNeg} == 3'b010, "R1", "idle outputs",
          {lineOe, linePos, lineNeg}, 3'b010);

    // R6: five ones complete a run with the sync's final 1
    for (int i = 0; i < 5; i++) pay[i] = 1'b1;
    runPacket(5, 1'b1);
    // R4: long run of ones
    for (int i = 0; i < 40; i++) pay[i] = 1'b1;
    runPacket(40, 1'b1);
    // R3: all zeros
    for (int i = 0; i < 16; i++) pay[i] = 1'b0;
    runPacket(16, 1'b1);
    // R10: source drops valid mid packet, and an empty packet
    for (int i = 0; i < 12; i++) pay[i] = 1'b1;
    runPacket(12, 1'b0);
    runPacket(0, 1'b0);
    // Random payloads, biased toward ones to provoke insertions
    for (int p = 0; p < 40; p++) begin
      int n = 1 + int'($urandom_range(0, 47));
      for (int i = 0; i < n; i++) pay[i] = ($urandom_range(0, 3) != 0);
      runPacket(n, ($urandom_range(0, 4) != 0));
      if ($urandom_range(0, 1) != 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end
    @(negedge clk);
    check({lineOe, linePos, lineNeg, inReady} == 4'b0100, "R1", "idle after traffic",
          {lineOe, linePos, lineNeg, inReady}, 4'b0100);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule